// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block resolves conditional branches for a processor that has no condition flags. A compare operation stores both raw 32-bit operands in a pair of latches. A later branch names a relation, signed or unsigned, and the unit tests that relation on the stored pair. It then works out whether the branch is taken and what the next program counter is.

Each branch carries a 4-bit condition code, a 10-bit signed half-word offset and the program counter of the branch itself. The result is registered and appears one cycle after the branch strobe, marked by a one-cycle valid pulse. Condition codes with no assigned relation never branch and raise an illegal-condition flag, which the surrounding core can route to its exception logic.

Top module: `brcmp_unit`

## Requirements
- R1: While reset is asserted and after it is released, both operand latches hold zero and res_valid, res_taken, res_illegal and res_next_pc are all zero until the first branch.
- R2: When cmp_en is high at a clock edge, cmp_a is stored as the left operand and cmp_b as the right operand. Without cmp_en the stored pair keeps its value, and no other output changes because of a compare.
- R3: res_valid is high in exactly the cycle after a cycle with br_en high. The result outputs keep their previous values while no branch is presented.
- R4: Signed relations compare left against right as two's complement numbers: code 0 equal, 1 not equal, 2 less than, 3 greater than, 6 greater or equal, 7 less or equal.
- R5: Unsigned relations compare left against right as unsigned numbers: code 4 less than, 5 greater than, 8 greater or equal, 9 less or equal.
- R6: A taken branch sets res_next_pc to br_pc + 2 + (br_ofs sign-extended from bit 9, times 2). The offset range is -1024 to +1022 bytes.
- R7: A branch that is not taken sets res_next_pc to br_pc + 2.
- R8: Condition codes 10 to 15 give res_taken = 0, res_illegal = 1 and res_next_pc = br_pc + 2. Valid codes give res_illegal = 0.
- R9: When a compare and a branch arrive in the same cycle, the branch is evaluated on the operands stored before that compare, and the new operands apply from the next branch on.
- R10: All program-counter arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare strobe: store the two operands |
| cmp_a | input | 32 | Left operand of the compare |
| cmp_b | input | 32 | Right operand of the compare |
| br_en | input | 1 | Branch strobe |
| br_cond | input | 4 | Condition code, 0 to 9 valid |
| br_ofs | input | 10 | Signed half-word branch offset |
| br_pc | input | 32 | Program counter of the branch |
| res_valid | output | 1 | One-cycle pulse: result fields are fresh |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Next program counter |
| res_illegal | output | 1 | Condition code had no relation |

## Verification
The assertions assume that br_cond, br_ofs and br_pc are stable and defined whenever br_en is high, and that cmp_a and cmp_b are defined whenever cmp_en is high. The properties that look at earlier cycles compare registered results with the branch inputs one cycle back, so they rely on those inputs being sampled at the strobe edge. The bench changes every input only on the falling clock edge and returns the strobes low after one cycle, so each operation is seen at exactly one rising edge with settled values.

// File: rtl/brcmp_pkg.sv
package brcmp_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 10;
  localparam int unsigned COND_W = 4;

  // The encoding is fixed: the instruction decoder places it in the opcode.
  typedef enum logic [COND_W-1:0] {
    BC_EQ  = 4'd0,
    BC_NE  = 4'd1,
    BC_LT  = 4'd2,
    BC_GT  = 4'd3,
    BC_LTU = 4'd4,
    BC_GTU = 4'd5,
    BC_GE  = 4'd6,
    BC_LE  = 4'd7,
    BC_GEU = 4'd8,
    BC_LEU = 4'd9
  } br_cond_e;

endpackage

// File: rtl/brcmp_opnd_latch.sv
module brcmp_opnd_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] opnd_l,
  output logic [W-1:0] opnd_r
);

  logic [W-1:0] l_q, l_d;
  logic [W-1:0] r_q, r_d;

  always_comb begin
    l_d = l_q;
    r_d = r_q;
    if (cap_en) begin
      l_d = in_l;
      r_d = in_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else begin
      l_q <= l_d;
      r_q <= r_d;
    end
  end

  assign opnd_l = l_q;
  assign opnd_r = r_q;

  // R2: a strobe stores both operands in their own slots
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (opnd_l == $past(in_l)) && (opnd_r == $past(in_r)));

  // R2: without a strobe the stored pair stays put
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(opnd_l) && $stable(opnd_r));

endmodule

// File: rtl/brcmp_rel_eval.sv
module brcmp_rel_eval
  import brcmp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [COND_W-1:0] cond,
  input  logic [W-1:0]      opnd_l,
  input  logic [W-1:0]      opnd_r,
  output logic              take,
  output logic              bad_cond
);

  logic is_eq, s_lt, u_lt;

  always_comb begin
    is_eq = (opnd_l == opnd_r);
    s_lt  = ($signed(opnd_l) < $signed(opnd_r));
    u_lt  = (opnd_l < opnd_r);
  end

  always_comb begin
    take     = 1'b0;
    bad_cond = 1'b0;
    case (br_cond_e'(cond))
      BC_EQ:   take = is_eq;
      BC_NE:   take = !is_eq;
      BC_LT:   take = s_lt;
      BC_GT:   take = !s_lt && !is_eq;
      BC_GE:   take = !s_lt;
      BC_LE:   take = s_lt || is_eq;
      BC_LTU:  take = u_lt;
      BC_GTU:  take = !u_lt && !is_eq;
      BC_GEU:  take = !u_lt;
      BC_LEU:  take = u_lt || is_eq;
      default: bad_cond = 1'b1;
    endcase
  end

endmodule

// File: rtl/brcmp_tgt_calc.sv
module brcmp_tgt_calc #(
  parameter int unsigned W     = 32,
  parameter int unsigned OFS_W = 10
) (
  input  logic [W-1:0]     pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [W-1:0]     seq_pc,
  output logic [W-1:0]     jump_pc
);

  localparam int unsigned EXT_W  = W - OFS_W - 1;
  localparam logic [W-1:0] STEP  = W'(2);

  logic [W-1:0] ofs_bytes;

  // sign-extend the half-word offset and scale it to bytes
  assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};

  always_comb begin
    seq_pc  = pc + STEP;
    jump_pc = seq_pc + ofs_bytes;
  end

endmodule

// File: rtl/brcmp_unit.sv
module brcmp_unit
  import brcmp_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned OFS_B = OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic [W-1:0]     cmp_a,
  input  logic [W-1:0]     cmp_b,
  input  logic             br_en,
  input  logic [3:0]       br_cond,
  input  logic [OFS_B-1:0] br_ofs,
  input  logic [W-1:0]     br_pc,
  output logic             res_valid,
  output logic             res_taken,
  output logic [W-1:0]     res_next_pc,
  output logic             res_illegal
);

  localparam logic [W-1:0] STEP = W'(2);
  localparam logic [3:0]   LAST_OK = 4'd9;

  logic [W-1:0] lat_l, lat_r;
  logic         take, bad_cond;
  logic [W-1:0] seq_pc, jump_pc;

  brcmp_opnd_latch #(.W(W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cmp_en),
    .in_l   (cmp_a),
    .in_r   (cmp_b),
    .opnd_l (lat_l),
    .opnd_r (lat_r)
  );

  brcmp_rel_eval #(.W(W)) u_eval (
    .cond     (br_cond),
    .opnd_l   (lat_l),
    .opnd_r   (lat_r),
    .take     (take),
    .bad_cond (bad_cond)
  );

  brcmp_tgt_calc #(.W(W), .OFS_W(OFS_B)) u_tgt (
    .pc      (br_pc),
    .ofs     (br_ofs),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  logic         vld_q, vld_d;
  logic         tkn_q, tkn_d;
  logic         ill_q, ill_d;
  logic [W-1:0] npc_q, npc_d;

  always_comb begin
    vld_d = br_en;
    tkn_d = tkn_q;
    ill_d = ill_q;
    npc_d = npc_q;
    if (br_en) begin
      tkn_d = take;
      ill_d = bad_cond;
      npc_d = take ? jump_pc : seq_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tkn_q <= 1'b0;
      ill_q <= 1'b0;
      npc_q <= '0;
    end else begin
      vld_q <= vld_d;
      tkn_q <= tkn_d;
      ill_q <= ill_d;
      npc_q <= npc_d;
    end
  end

  assign res_valid   = vld_q;
  assign res_taken   = tkn_q;
  assign res_illegal = ill_q;
  assign res_next_pc = npc_q;

  // R3: one result pulse per branch, one cycle later
  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_en |=> res_valid);

  // R3: idle cycles leave the result fields alone
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !br_en |=> !res_valid && $stable(res_next_pc) && $stable(res_taken));

  // R8: the illegal flag tracks the code range of the branch that produced it
  p_illegal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_en |=> res_illegal == ($past(br_cond) > LAST_OK));

  // R8: an illegal code never redirects the flow
  p_no_jump_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_illegal |-> !res_taken);

  // R7: fall-through result is the next half-word after the branch
  p_seq_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_taken |-> res_next_pc == $past(br_pc) + STEP);

endmodule

// File: tb/brcmp_unit_tb.sv
module brcmp_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cmp_en;
  logic [31:0] cmp_a, cmp_b;
  logic        br_en;
  logic [3:0]  br_cond;
  logic [9:0]  br_ofs;
  logic [31:0] br_pc;
  logic        res_valid, res_taken, res_illegal;
  logic [31:0] res_next_pc;

  int checks = 0;
  int errors = 0;

  brcmp_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_en      (cmp_en),
    .cmp_a       (cmp_a),
    .cmp_b       (cmp_b),
    .br_en       (br_en),
    .br_cond     (br_cond),
    .br_ofs      (br_ofs),
    .br_pc       (br_pc),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_next_pc (res_next_pc),
    .res_illegal (res_illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // reference relation from the requirement table (R4, R5)
  function automatic logic ref_take(input int c, input logic [31:0] l, input logic [31:0] r);
    case (c)
      0: return l == r;
      1: return l != r;
      2: return $signed(l) <  $signed(r);
      3: return $signed(l) >  $signed(r);
      4: return l <  r;
      5: return l >  r;
      6: return $signed(l) >= $signed(r);
      7: return $signed(l) <= $signed(r);
      8: return l >= r;
      9: return l <= r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] ref_target(input logic [31:0] pc, input logic [9:0] ofs);
    int signed o;
    o = $signed({{22{ofs[9]}}, ofs}) * 2;
    return pc + 32'd2 + o;
  endfunction

  task automatic do_cmp(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    cmp_en = 1'b1; cmp_a = l; cmp_b = r;
    @(negedge clk);
    cmp_en = 1'b0;
  endtask

  // present a branch; outputs are sampled on the following falling edge
  task automatic do_br(input int c, input logic [9:0] ofs, input logic [31:0] pc);
    @(negedge clk);
    br_en = 1'b1; br_cond = 4'(c); br_ofs = ofs; br_pc = pc;
    @(negedge clk);
    br_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 taken", 32'(res_taken), 32'd0);
    check("R1 illegal", 32'(res_illegal), 32'd0);
    check("R1 next_pc", res_next_pc, 32'd0);
    // zero latches: EQ taken, LTU and GT not taken
    do_br(0, 10'd4, 32'h100);
    check("R1 eq on zero latches", 32'(res_taken), 32'd1);
    do_br(4, 10'd4, 32'h100);
    check("R1 ltu on zero latches", 32'(res_taken), 32'd0);
    do_br(3, 10'd4, 32'h100);
    check("R1 gt on zero latches", 32'(res_taken), 32'd0);
  endtask

  task automatic t_sweep;
    logic [31:0] vals [4];
    vals[0] = 32'h0; vals[1] = 32'hFFFF_FFFF; vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        do_cmp(vals[i], vals[j]);
        for (int c = 0; c < 10; c++) begin
          logic e;
          e = ref_take(c, vals[i], vals[j]);
          do_br(c, 10'd8, 32'h2000);
          check((c == 4 || c == 5 || c == 8 || c == 9) ? "R5 unsigned taken" : "R4 signed taken",
                32'(res_taken), 32'(e));
          check(e ? "R6 taken target" : "R7 fall-through", res_next_pc,
                e ? ref_target(32'h2000, 10'd8) : 32'h2002);
          check("R3 valid pulse", 32'(res_valid), 32'd1);
          check("R8 legal code not flagged", 32'(res_illegal), 32'd0);
        end
      end
    end
  endtask

  task automatic t_offsets;
    do_cmp(32'd7, 32'd7);
    do_br(0, 10'h1FF, 32'h1000);
    check("R6 max positive offset", res_next_pc, 32'h1400);
    do_br(0, 10'h200, 32'h1000);
    check("R6 max negative offset", res_next_pc, 32'h0C02);
    do_br(1, 10'h200, 32'h1000);
    check("R7 not taken ignores offset", res_next_pc, 32'h1002);
    do_br(0, 10'd0, 32'hFFFF_FFFE);
    check("R10 wrap taken", res_next_pc, 32'h0);
    do_br(0, 10'h200, 32'h0000_0010);
    check("R10 wrap backward", res_next_pc, 32'hFFFF_FC12);
  endtask

  task automatic t_illegal;
    do_cmp(32'd3, 32'd3);
    for (int c = 10; c < 16; c++) begin
      do_br(c, 10'h0FF, 32'h3000);
      check("R8 illegal flag", 32'(res_illegal), 32'd1);
      check("R8 illegal not taken", 32'(res_taken), 32'd0);
      check("R8 illegal next_pc", res_next_pc, 32'h3002);
    end
    do_br(0, 10'h0FF, 32'h3000);
    check("R8 legal clears flag", 32'(res_illegal), 32'd0);
  endtask

  task automatic t_same_cycle;
    do_cmp(32'd5, 32'd5);
    @(negedge clk);
    cmp_en = 1'b1; cmp_a = 32'd1; cmp_b = 32'd2;
    br_en = 1'b1; br_cond = 4'd0; br_ofs = 10'd2; br_pc = 32'h4000;
    @(negedge clk);
    cmp_en = 1'b0; br_en = 1'b0;
    check("R9 branch uses old operands", 32'(res_taken), 32'd1);
    do_br(0, 10'd2, 32'h4000);
    check("R9 new operands apply next", 32'(res_taken), 32'd0);
    do_br(2, 10'd2, 32'h4000);
    check("R9 new operands lt", 32'(res_taken), 32'd1);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    do_cmp(32'h8000_0000, 32'd1);
    do_br(4, 10'd6, 32'h5000);
    keep = res_next_pc;
    check("R2 compare stored unsigned", 32'(res_taken), 32'd0);
    @(negedge clk);
    check("R3 valid drops when idle", 32'(res_valid), 32'd0);
    check("R3 next_pc held when idle", res_next_pc, keep);
    // a compare alone must not touch result outputs
    do_cmp(32'd9, 32'd9);
    check("R2 compare leaves valid low", 32'(res_valid), 32'd0);
    check("R2 compare leaves next_pc", res_next_pc, keep);
    repeat (5) @(negedge clk);
    do_br(0, 10'd6, 32'h5000);
    check("R2 pair kept across idle", 32'(res_taken), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; cmp_en = 1'b0; cmp_a = '0; cmp_b = '0;
    br_en = 1'b0; br_cond = '0; br_ofs = '0; br_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_offsets();
    t_illegal();
    t_same_cycle();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule